// File: doc/BRIEF.md
# Early-Terminating Integer Divider

This block divides one 32-bit integer by another and returns a 32-bit quotient. A mode input selects whether the operands are unsigned or two's-complement signed. It has no remainder output. A caller who needs the remainder computes the dividend minus the product of quotient and divisor.

The divider uses a restoring shift-subtract loop that finds one quotient bit per clock. Before the loop starts, it compares the leading-one positions of the two magnitudes. Every quotient bit above the difference between those positions must be zero, so the loop skips them. Operands of similar size therefore finish in a few cycles, and a full-range quotient takes 34. Signed operands are converted to magnitudes first, and the result is negated at the end when the operand signs differ.

A one-cycle `start` pulse loads the operands while the divider is idle. `busy` stays high while the work is in progress. `done` pulses for one cycle when `quotient` is updated.

Top module: `early_divider`

## Requirements
- R1: With `is_signed`=0, `quotient` equals the unsigned floor of `dividend / divisor` for any nonzero divisor.
- R2: With `is_signed`=1, the operands are read as two's complement. The quotient is truncated toward zero and is negative exactly when the operand signs differ and the true result is nonzero.
- R3: A zero divisor gives `quotient` = 0, with `done` on the 2nd rising edge after the edge that sampled `start`.
- R4: When the divisor magnitude is larger than the dividend magnitude (including a zero dividend), `quotient` = 0, with `done` on the 2nd edge after the start edge.
- R5: Otherwise `done` rises on edge s+3 after the start edge, where s is the bit index of the dividend magnitude's leading one minus that of the divisor's. The largest latency is therefore 34.
- R6: In signed mode, 0x80000000 divided by 0xFFFFFFFF (−1) returns 0x80000000 with no other indication.
- R7: `busy` is high from the edge that samples `start` until the edge that raises `done`. `done` lasts exactly one cycle, and `busy` is low while `done` is high.
- R8: A `start` pulse while `busy` is high is ignored. The running division completes with its original operands.
- R9: Reset clears `busy`, `done` and `quotient`. `quotient` changes only on the edge that raises `done`, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division; sampled only while idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | 32 | Numerator |
| divisor | input | 32 | Denominator |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle pulse when the result is written |
| quotient | output | 32 | Last result, held until the next completion |

## Verification
Unsigned pairs are run at three distances between the operands' leading ones: zero, a few bits and the full 31. These show that skipping bits leaves the quotient unchanged and that the latency follows that distance. The four sign combinations of the same magnitudes test the negation and truncation toward zero. The most negative value divided by −1 tests the wrap case. A zero divisor and a divisor larger than the dividend test the short exit, which must return zero and must not enter the loop. Random operands with random magnitude widths cover every skip depth. A restart pulse while the divider is busy must leave the running result unchanged.

// File: rtl/early_divider.sv
module early_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int LW = $clog2(W);

  typedef enum logic [1:0] {IDLE, PREP, RUN, FIX} st_t;
  st_t st;

  logic [W-1:0]  mag_n, mag_d, rem, dsh, q_acc;
  logic [LW-1:0] cnt;
  logic          neg;

  function automatic logic [LW-1:0] lead1(input logic [W-1:0] v);
    logic [LW-1:0] p;
    p = '0;
    for (int i = 0; i < W; i++)
      if (v[i]) p = LW'(i);
    return p;
  endfunction

  wire n_neg  = is_signed & dividend[W-1];
  wire d_neg  = is_signed & divisor[W-1];
  wire [W-1:0] abs_n = n_neg ? -dividend : dividend;
  wire [W-1:0] abs_d = d_neg ? -divisor  : divisor;

  wire           trivial = (mag_d == '0) || (mag_d > mag_n);
  wire [LW-1:0]  skip    = lead1(mag_n) - lead1(mag_d);
  wire           ge      = rem >= dsh;

  assign busy = (st != IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= IDLE;
      mag_n    <= '0;
      mag_d    <= '0;
      rem      <= '0;
      dsh      <= '0;
      q_acc    <= '0;
      cnt      <= '0;
      neg      <= 1'b0;
      done     <= 1'b0;
      quotient <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        IDLE: if (start) begin
          mag_n <= abs_n;
          mag_d <= abs_d;
          neg   <= n_neg ^ d_neg;
          st    <= PREP;
        end
        PREP: begin
          q_acc <= '0;
          rem   <= mag_n;
          dsh   <= mag_d << skip;
          cnt   <= skip;
          st    <= trivial ? FIX : RUN;
        end
        RUN: begin
          rem   <= ge ? rem - dsh : rem;
          q_acc <= {q_acc[W-2:0], ge};
          dsh   <= dsh >> 1;
          if (cnt == '0) st <= FIX;
          else cnt <= cnt - 1'b1;
        end
        FIX: begin
          quotient <= neg ? -q_acc : q_acc;
          done     <= 1'b1;
          st       <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r8_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(mag_n) && $stable(mag_d) && $stable(neg)));

  a_r9_quot_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(quotient) |-> done);

  a_r4_short_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PREP && trivial) |=> (st == FIX && q_acc == '0));

  a_r5_loop_remainder_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RUN) |=> (st == FIX) || (rem < (dsh << 1)) || dsh[W-1]);
endmodule

// File: tb/sim_early_divider.sv
module sim_early_divider;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_signed = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done;
  logic [31:0] quotient;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  early_divider u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient)
  );

  localparam int NV = 12;
  localparam logic [31:0] TN [NV] = '{32'd100, 32'hFFFFFFFF, 32'd5, 32'd3,
    32'hFFFFFFF9, 32'd7, 32'hFFFFFFF9, 32'h80000000, 32'hFFFFFFF0,
    32'h80000000, 32'hFFFFFFFF, 32'd0};
  localparam logic [31:0] TD [NV] = '{32'd7, 32'd1, 32'd0, 32'd10,
    32'd2, 32'hFFFFFFFE, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h10,
    32'hFFFFFFFF, 32'd1, 32'd5};
  localparam logic        TS [NV] = '{1'b0, 1'b0, 1'b0, 1'b0,
    1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic [31:0] TQ [NV] = '{32'd14, 32'hFFFFFFFF, 32'd0, 32'd0,
    32'hFFFFFFFD, 32'hFFFFFFFD, 32'd3, 32'h80000000, 32'h0FFFFFFF,
    32'd0, 32'hFFFFFFFF, 32'd0};

  function automatic int msb(input logic [31:0] v);
    int p = 0;
    for (int i = 0; i < 32; i++) if (v[i]) p = i;
    return p;
  endfunction

  function automatic logic [31:0] mag(input logic [31:0] v, input logic s);
    return (s && v[31]) ? -v : v;
  endfunction

  function automatic int exp_lat(input logic [31:0] n, input logic [31:0] d, input logic s);
    logic [31:0] an, ad;
    an = mag(n, s);
    ad = mag(d, s);
    if (ad == 0 || ad > an) return 2;
    return msb(an) - msb(ad) + 3;
  endfunction

  function automatic logic [31:0] ref_q(input logic [31:0] n, input logic [31:0] d, input logic s);
    if (d == 0) return 0;
    if (!s) return n / d;
    if (n == 32'h80000000 && d == 32'hFFFFFFFF) return 32'h80000000;
    return $signed(n) / $signed(d);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] n, input logic [31:0] d, input logic s,
                     input logic [31:0] expq, input bit poke, input string tag);
    int lat;
    @(negedge clk);
    dividend = n; divisor = d; is_signed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, {tag, " R7 busy after start"}, {31'd0, busy}, 32'd1);
    lat = 0;
    while (done !== 1'b1 && lat < 60) begin
      @(negedge clk);
      lat++;
      if (poke && lat == 1) begin
        dividend = 32'd1; divisor = 32'd1; is_signed = 1'b0; start = 1'b1;
      end else start = 1'b0;
    end
    start = 1'b0;
    check(quotient === expq, tag, quotient, expq);
    check(lat == exp_lat(n, d, s), {tag, " R5 latency"}, 32'(lat), 32'(exp_lat(n, d, s)));
    check(busy === 1'b0, {tag, " R7 busy low with done"}, {31'd0, busy}, 32'd0);
    @(negedge clk);
    check(done === 1'b0, {tag, " R7 done one cycle"}, {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && quotient === 32'd0, "R9 reset state",
          quotient, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      check(TQ[i] === ref_q(TN[i], TD[i], TS[i]), "R1/R2 table model", TQ[i],
            ref_q(TN[i], TD[i], TS[i]));
      run(TN[i], TD[i], TS[i], TQ[i], 1'b0,
          TD[i] == 0 ? "R3 zero divisor" :
          (TN[i] == 32'h80000000 && TS[i]) ? "R6 wrap" :
          TS[i] ? "R2 signed" : "R1 unsigned");
    end

    run(32'd1000, 32'd3, 1'b0, 32'd333, 1'b1, "R8 restart ignored");

    repeat (5) @(negedge clk);
    check(quotient === 32'd333, "R9 quotient holds", quotient, 32'd333);

    run(32'd9, 32'd9, 1'b0, 32'd1, 1'b0, "R5 equal operands");
    run(32'd2, 32'hFFFFFFFD, 1'b1, 32'd0, 1'b0, "R4 larger divisor");

    for (int k = 0; k < 60; k++) begin
      logic [31:0] n, d;
      logic s;
      n = $urandom() >> ($urandom() % 32);
      d = $urandom() >> ($urandom() % 32);
      s = 1'($urandom());
      run(n, d, s, ref_q(n, d, s), 1'b0, s ? "R2 random" : "R1 random");
    end

    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule